// File: doc/BRIEF.md
# CORDIC Phase Difference Detector

This block measures the phase angle between two complex baseband samples: a cavity-probe I/Q pair and a forward-power I/Q pair. A frequency-tuning regulation loop uses the angle as its error signal. The block first forms the product of the cavity vector and the complex conjugate of the forward vector. The angle of that product equals the cavity angle minus the forward angle. The block then resolves the angle with an iterative vectoring CORDIC that performs one micro-rotation per clock.

A caller presents both vectors and pulses `start` while the block is idle. The block captures the inputs on that edge and runs a fixed number of micro-rotations, 16 by default. At 80 MHz this takes about 200 ns. It then raises `done` for one cycle and updates `phase`, which holds its value until the next result. Before the iterations begin, a pre-map stage turns a product that lies in the left half-plane by half a turn. This lets the result cover the whole circle.

Top module: `cordic_phase_diff`

## Requirements
- R1: While reset is asserted and just after it is released, `busy` and `done` are 0 and `phase` is 0.
- R2: `phase` is the angle of cav·conj(fwd) = (ci·fi + cq·fq) + j(cq·fi − ci·fq). It is a signed 32-bit binary angle in which 2^31 units equal 180 degrees and positive means counter-clockwise. For ITER=16 the error is within ±65536 units (about 0.0055 degree).
- R3: Products whose real part is negative, including angles near ±180 degrees, come out to the same accuracy as R2. The angle wraps modulo 2^32, so a result of exactly 180 degrees reads as 0x8000_0000.
- R4: `done` is high for exactly one cycle, after the ITER-th rising edge that follows the edge on which `start` was accepted.
- R5: `busy` is high from the edge after acceptance until `done` rises. A `start` that arrives while `busy` is high is ignored: it produces neither a new result nor an extra `done`.
- R6: `phase` changes only on the edge that raises `done` and holds otherwise, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a measurement; sampled only while idle |
| cav_i | input | IN_W | Cavity in-phase sample, signed |
| cav_q | input | IN_W | Cavity quadrature sample, signed |
| fwd_i | input | IN_W | Forward in-phase sample, signed |
| fwd_q | input | IN_W | Forward quadrature sample, signed |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle result strobe |
| phase | output | ANG_W | Phase difference, binary angle |

## Verification
The bench sweeps the cavity vector around the full circle in 15-degree steps against eight forward-vector angles, using unequal amplitudes. This exercises every quadrant of the product, both branches of the pre-map, and the sign of each micro-rotation. The axis cases follow: phase differences of exactly 0, ±90 and 180 degrees, and angles just on either side of the ±180-degree seam. These separate a correct wrap from an off-by-half-turn result. Full-scale negative inputs test the guard-bit headroom. A start issued mid-computation, and inputs that change after a result, show whether the block accepts work only while idle and whether `phase` holds.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int ANG_W = 32;

  // arctangent of 2^-i in binary angle units (2^31 = half turn)
  function automatic logic [ANG_W-1:0] atan_step(input int unsigned i);
    logic [ANG_W-1:0] v;
    case (i)
      0:  v = 32'h2000_0000;
      1:  v = 32'h12E4_051E;
      2:  v = 32'h09FB_385B;
      3:  v = 32'h0511_11D4;
      4:  v = 32'h028B_0D43;
      5:  v = 32'h0145_D7E1;
      6:  v = 32'h00A2_F61E;
      7:  v = 32'h0051_7C55;
      8:  v = 32'h0028_BE53;
      9:  v = 32'h0014_5F2F;
      10: v = 32'h000A_2F98;
      11: v = 32'h0005_17CC;
      12: v = 32'h0002_8BE6;
      13: v = 32'h0001_45F3;
      14: v = 32'h0000_A2FA;
      15: v = 32'h0000_517D;
      default: v = 32'h0000_A2FA >> (i - 14);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cpd_atan_rom.sv
module cpd_atan_rom
  import cpd_pkg::*;
#(
  parameter int ITER = 16,
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic [CW-1:0]    idx,
  output logic [ANG_W-1:0] step
);
  logic [ANG_W-1:0] table_q [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_ent
    assign table_q[g] = atan_step(g);
  end

  always_comb begin
    step = '0;
    for (int k = 0; k < ITER; k++) begin
      if (idx == CW'(k)) step = table_q[k];
    end
  end
endmodule

// File: rtl/cpd_premap.sv
module cpd_premap
  import cpd_pkg::*;
#(
  parameter int IN_W = 16,
  localparam int PW = 2 * IN_W + 1,
  localparam int XW = PW + 2
) (
  input  logic signed [IN_W-1:0] cav_i,
  input  logic signed [IN_W-1:0] cav_q,
  input  logic signed [IN_W-1:0] fwd_i,
  input  logic signed [IN_W-1:0] fwd_q,
  output logic signed [XW-1:0]   x_o,
  output logic signed [XW-1:0]   y_o,
  output logic [ANG_W-1:0]       z_o
);
  logic signed [PW-1:0] ci, cq, fi, fq;
  logic signed [PW-1:0] re, im;
  logic signed [XW-1:0] re_x, im_x;

  always_comb begin
    ci = PW'(cav_i);
    cq = PW'(cav_q);
    fi = PW'(fwd_i);
    fq = PW'(fwd_q);
    // cavity times conjugate of forward
    re = ci * fi + cq * fq;
    im = cq * fi - ci * fq;
    re_x = XW'(re);
    im_x = XW'(im);
    if (re_x[XW-1]) begin
      x_o = -re_x;
      y_o = -im_x;
      z_o = {1'b1, {(ANG_W-1){1'b0}}};
    end else begin
      x_o = re_x;
      y_o = im_x;
      z_o = '0;
    end
  end
endmodule

// File: rtl/cpd_engine.sv
module cpd_engine
  import cpd_pkg::*;
#(
  parameter int XW = 35,
  parameter int ITER = 16,
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1,
  localparam logic [CW-1:0] LAST = CW'(ITER - 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [XW-1:0] x_in,
  input  logic signed [XW-1:0] y_in,
  input  logic [ANG_W-1:0]     z_in,
  input  logic [ANG_W-1:0]     step,
  output logic [CW-1:0]        idx,
  output logic                 busy,
  output logic                 done,
  output logic [ANG_W-1:0]     phase
);
  logic signed [XW-1:0] x_r, y_r, x_n, y_n, x_sh, y_sh;
  logic [ANG_W-1:0]     z_r, z_n, ph_r, ph_n;
  logic [CW-1:0]        cnt_r, cnt_n;
  logic                 busy_r, busy_n, done_r, done_n;
  logic                 dp_en;

  assign x_sh  = x_r >>> cnt_r;
  assign y_sh  = y_r >>> cnt_r;
  assign dp_en = busy_r | load;

  always_comb begin
    x_n    = x_r;
    y_n    = y_r;
    z_n    = z_r;
    cnt_n  = cnt_r;
    busy_n = busy_r;
    done_n = 1'b0;
    ph_n   = ph_r;
    if (!busy_r) begin
      if (load) begin
        x_n    = x_in;
        y_n    = y_in;
        z_n    = z_in;
        cnt_n  = '0;
        busy_n = 1'b1;
      end
    end else begin
      if (!y_r[XW-1]) begin
        x_n = x_r + y_sh;
        y_n = y_r - x_sh;
        z_n = z_r + step;
      end else begin
        x_n = x_r - y_sh;
        y_n = y_r + x_sh;
        z_n = z_r - step;
      end
      if (cnt_r == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        ph_n   = z_n;
      end else begin
        cnt_n = cnt_r + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_r    <= '0;
      y_r    <= '0;
      z_r    <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
      ph_r   <= '0;
    end else begin
      busy_r <= busy_n;
      done_r <= done_n;
      if (dp_en) begin
        x_r   <= x_n;
        y_r   <= y_n;
        z_r   <= z_n;
        cnt_r <= cnt_n;
      end
      if (done_n) ph_r <= ph_n;
    end
  end

  assign idx   = cnt_r;
  assign busy  = busy_r;
  assign done  = done_r;
  assign phase = ph_r;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |=> !done_r);
  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> ($past(busy_r) && !busy_r));
  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && load && cnt_r != LAST) |=> (busy_r && cnt_r == $past(cnt_r) + 1'b1));
  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_r |-> $stable(ph_r));
  // R3
  x_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |-> !x_r[XW-1]);
endmodule

// File: rtl/cordic_phase_diff.sv
module cordic_phase_diff
  import cpd_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int ITER = 16,
  localparam int PW = 2 * IN_W + 1,
  localparam int XW = PW + 2,
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic signed [IN_W-1:0] cav_i,
  input  logic signed [IN_W-1:0] cav_q,
  input  logic signed [IN_W-1:0] fwd_i,
  input  logic signed [IN_W-1:0] fwd_q,
  output logic                   busy,
  output logic                   done,
  output logic [ANG_W-1:0]       phase
);
  logic                 rst_s1, rst_s2;
  logic signed [XW-1:0] x0, y0;
  logic [ANG_W-1:0]     z0, step;
  logic [CW-1:0]        idx;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  cpd_premap #(.IN_W(IN_W)) u_premap (
    .cav_i(cav_i), .cav_q(cav_q), .fwd_i(fwd_i), .fwd_q(fwd_q),
    .x_o(x0), .y_o(y0), .z_o(z0)
  );

  cpd_atan_rom #(.ITER(ITER)) u_rom (
    .idx(idx), .step(step)
  );

  cpd_engine #(.XW(XW), .ITER(ITER)) u_engine (
    .clk(clk), .rst_n(rst_s2), .load(start),
    .x_in(x0), .y_in(y0), .z_in(z0), .step(step), .idx(idx),
    .busy(busy), .done(done), .phase(phase)
  );
endmodule

// File: tb/cordic_phase_diff_tb.sv
module cordic_phase_diff_tb;
  localparam int IN_W = 16;
  localparam int ITER = 16;
  localparam int TOL = 65536;
  localparam real PI = 3.14159265358979;

  logic clk, rst_n, start, busy, done;
  logic signed [IN_W-1:0] cav_i, cav_q, fwd_i, fwd_q;
  logic [31:0] phase;
  int total, bad;

  cordic_phase_diff #(.IN_W(IN_W), .ITER(ITER)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cav_i(cav_i), .cav_q(cav_q), .fwd_i(fwd_i), .fwd_q(fwd_q),
    .busy(busy), .done(done), .phase(phase)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_angle(input int ci, cq, fi, fq);
    longint re, im;
    real a;
    re = longint'(ci) * fi + longint'(cq) * fq;
    im = longint'(cq) * fi - longint'(ci) * fq;
    a = $atan2(real'(im), real'(re)) / PI * 2147483648.0;
    if (a >= 2147483648.0) a = a - 4294967296.0;
    return 32'(longint'(a));
  endfunction

  // issue one measurement and check latency, strobe and value
  task automatic run_case(input int ci, cq, fi, fq, input bit mid_start);
    logic [31:0] expv;
    logic signed [31:0] d;
    int lat_ok;
    longint re;
    expv = ref_angle(ci, cq, fi, fq);
    re = longint'(ci) * fi + longint'(cq) * fq;
    cav_i = IN_W'(ci); cav_q = IN_W'(cq); fwd_i = IN_W'(fi); fwd_q = IN_W'(fq);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    lat_ok = 1;
    for (int i = 1; i <= ITER; i++) begin
      @(posedge clk); #2;
      if (i < ITER && (done || !busy)) lat_ok = 0;
      if (i == ITER && (!done || busy)) lat_ok = 0;
      if (mid_start && i == 5) begin
        cav_i = 16'sd1000; cav_q = -16'sd20000; fwd_i = -16'sd5000; fwd_q = 16'sd300;
        start = 1'b1;
      end
      if (mid_start && i == 6) start = 1'b0;
    end
    chk(lat_ok == 1, "R4/R5 done latency and busy window", lat_ok, 1);
    d = phase - expv;
    if (re < 0)
      chk(d <= TOL && d >= -TOL, "R3 left half-plane angle", longint'(phase), longint'(expv));
    else
      chk(d <= TOL && d >= -TOL, "R2 angle", longint'(phase), longint'(expv));
    @(posedge clk); #2;
    chk(!done, "R4 done one cycle", done, 0);
  endtask

  initial begin
    int a1, a2;
    logic [31:0] held;
    int extra;
    total = 0; bad = 0;
    rst_n = 1'b0; start = 1'b0;
    cav_i = '0; cav_q = '0; fwd_i = '0; fwd_q = '0;
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !done && phase == 0, "R1 reset state", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(!busy && !done && phase == 0, "R1 after release", longint'(phase), 0);

    // full sweep: cavity angle 15 deg steps, forward angle 45 deg steps
    for (int b = 0; b < 8; b++) begin
      for (int a = 0; a < 24; a++) begin
        a1 = int'(20000.0 * $cos(a * 15.0 * PI / 180.0));
        a2 = int'(20000.0 * $sin(a * 15.0 * PI / 180.0));
        run_case(a1, a2, int'(12000.0 * $cos((b * 45.0 + 7.0) * PI / 180.0)),
                 int'(12000.0 * $sin((b * 45.0 + 7.0) * PI / 180.0)), 1'b0);
      end
    end

    // axis cases and the +-180 seam (R2, R3)
    run_case(20000, 0, 15000, 0, 1'b0);
    run_case(0, 20000, 15000, 0, 1'b0);
    run_case(0, -20000, 15000, 0, 1'b0);
    run_case(-20000, 0, 15000, 0, 1'b0);
    run_case(-20000, 10, 15000, 0, 1'b0);
    run_case(-20000, -10, 15000, 0, 1'b0);
    run_case(-32768, -32768, -32768, 0, 1'b0);
    run_case(-32768, -32768, 32767, 32767, 1'b0);
    run_case(32767, -32768, -32768, 32767, 1'b0);

    // R5: start during busy is ignored, no second done follows
    run_case(10000, 3000, -2000, 9000, 1'b1);
    extra = 0;
    for (int i = 0; i < 25; i++) begin
      @(posedge clk); #2;
      if (done || busy) extra++;
    end
    chk(extra == 0, "R5 ignored start gives no result", extra, 0);

    // R6: phase holds while inputs change and no start
    held = phase;
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      cav_i = IN_W'(i * 1111); cav_q = IN_W'(-i * 777); fwd_i = IN_W'(i * 50 + 1); fwd_q = IN_W'(i);
      @(posedge clk); #2;
      if (phase != held || done) extra++;
    end
    chk(extra == 0, "R6 phase holds", longint'(phase), longint'(held));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule